// File: doc/BRIEF.md
# Oversampled Serial Character Receiver with Status Byte

This block turns an asynchronous serial line into characters of five to eight data bits. It takes its timing from an enable that pulses sixteen times per bit period, which is generated elsewhere. It checks an optional parity bit and flags framing errors, break conditions and overrun. Every condition it detects is reported in one status byte.

The block has three write interfaces:
- A 4-bit mode write selects the character length and the parity rule.
- A control write carries a command nibble plus separate enable and disable strobes.
- A read strobe takes the character from the single holding register.

Software polls the ready bit in the status byte. It then reads the character and pulses the read strobe. Errors, overrun and break stay latched until the matching command clears them.

Top module: `uart_rx_status`

## Requirements
- R1: Mode bits [3:2] select the character length: code 0 gives 5 data bits, 1 gives 6, 2 gives 7 and 3 gives 8. The delivered character has zeros above its length. After reset the length is 8 and parity is off.
- R2: Mode bits [1:0] select parity: 0 none, 1 odd, 2 even, 3 space (the bit must be 0). A parity mismatch sets status bit 5, and the character is still delivered.
- R3: A stop bit sampled low on a frame that is not a break sets status bit 5, and the character is still delivered.
- R4: A frame whose data bits, parity bit and stop bit are all zero sets status bit 6, leaves bit 5 alone and delivers no character. No new start bit is accepted until the line has returned high.
- R5: A character that completes while the previous one is unread sets status bit 4 (overrun). The new character is discarded and the held one is kept.
- R6: A delivered character sets status bits 0 and 1 together. A read strobe clears both, and the character stays on `rx_char` until it is replaced.
- R7: The command field is control bits [7:4]:
  - Command 3 clears status bits 5 and 4.
  - Command 4 clears status bit 6.
  - Command 0, and any code not listed, changes nothing.
  - A clear wins over a new event in the same cycle.
- R8: Command 1 returns the receiver to idle, empties the holding register and zeroes `rx_char`. It leaves bits 4, 5 and 6 and the enable state unchanged.
- R9: Control bit 0 is an enable strobe and bit 1 a disable strobe, and disable wins when both are set. The receiver is disabled after reset. While disabled it ignores the line.
- R10: A start bit is confirmed by a sample 8 ticks after the low level is first seen, and a low pulse shorter than that is ignored. Data bits are sampled every 16 ticks, LSB first, followed by parity (if enabled) and then the stop bit.
- R11: During and after reset the status byte and `rx_char` are zero. The status bits 7, 3 and 2 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit period |
| rxd | input | 1 | Serial line, idle high |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control word: [7:4] command, [1] disable, [0] enable |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 4 | Mode: [3:2] length code, [1:0] parity code |
| rd | input | 1 | Read strobe, takes the held character |
| rx_char | output | 8 | Held character |
| status | output | 8 | Status: [6] break, [5] parity/framing error, [4] overrun, [1] full, [0] ready |

## Verification
The bench runs every length code against each parity rule. A design that sampled bits MSB first, or kept stale upper bits, would return a different value than the scoreboard expects. Deliberately wrong parity and a low stop bit must both raise the shared error bit while the character still arrives. An all-zero frame must raise only the break bit, and a receiver that failed to wait for the line to go high would later deliver a bogus character. The bench also checks four further cases:
- A second character sent without a read must leave the first one in place.
- A low glitch shorter than half a bit must deliver nothing.
- The clear commands must each touch only their own bits.
- A control word with both enable and disable set must leave the receiver deaf to the line.

// File: rtl/urx_pkg.sv
package urx_pkg;

  localparam int CHAR_W = 8;

  typedef enum logic [1:0] {
    PAR_NONE  = 2'd0,
    PAR_ODD   = 2'd1,
    PAR_EVEN  = 2'd2,
    PAR_SPACE = 2'd3
  } par_e;

  localparam logic [3:0] CMD_NOP       = 4'd0;
  localparam logic [3:0] CMD_RX_RESET  = 4'd1;
  localparam logic [3:0] CMD_ERR_CLEAR = 4'd3;
  localparam logic [3:0] CMD_BRK_CLEAR = 4'd4;

  localparam int ST_BRK = 6;
  localparam int ST_ERR = 5;
  localparam int ST_OVR = 4;
  localparam int ST_FULL = 1;
  localparam int ST_RDY = 0;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              err;
    logic              brk;
  } frame_t;

endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '1;
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/urx_ctrl.sv
module urx_ctrl
  import urx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  input  logic       mode_wr,
  input  logic [3:0] mode_wdata,
  output logic       rx_en,
  output logic [1:0] len_code,
  output par_e       par_mode,
  output logic       clr_rx,
  output logic       clr_err,
  output logic       clr_brk
);
  logic [3:0] mode_q;
  logic [3:0] cmd;
  logic       unused_ctl;

  assign cmd        = ctl_wdata[7:4];
  assign unused_ctl = ^ctl_wdata[3:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en  <= 1'b0;
      mode_q <= 4'b1100;
    end else begin
      if (ctl_wr && ctl_wdata[1])      rx_en <= 1'b0;
      else if (ctl_wr && ctl_wdata[0]) rx_en <= 1'b1;
      if (mode_wr) mode_q <= mode_wdata;
    end
  end

  assign len_code = mode_q[3:2];
  assign par_mode = par_e'(mode_q[1:0]);
  assign clr_rx   = ctl_wr && (cmd == CMD_RX_RESET);
  assign clr_err  = ctl_wr && (cmd == CMD_ERR_CLEAR);
  assign clr_brk  = ctl_wr && (cmd == CMD_BRK_CLEAR);
endmodule

// File: rtl/urx_deser.sv
module urx_deser
  import urx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       tick,
  input  logic       rxd,
  input  logic [1:0] len_code,
  input  par_e       par_mode,
  output logic       done,
  output frame_t     result
);
  localparam int CW   = $clog2(OSR);
  localparam int IW   = $clog2(CHAR_W);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAITHI} st_e;

  st_e               st;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic [IW-1:0]     last_idx;
  logic [CHAR_W-1:0] shreg;
  logic              parb;
  logic              par_ok;
  logic              is_brk;

  assign last_idx = IW'(CHAR_W - 4) + IW'(len_code);

  always_comb begin
    unique case (par_mode)
      PAR_ODD:   par_ok = (^shreg ^ parb) == 1'b1;
      PAR_EVEN:  par_ok = (^shreg ^ parb) == 1'b0;
      PAR_SPACE: par_ok = !parb;
      default:   par_ok = 1'b1;
    endcase
  end

  assign is_brk = (shreg == '0) && !parb && !rxd;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      st     <= S_IDLE;
      cnt    <= '0;
      idx    <= '0;
      shreg  <= '0;
      parb   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (tick && !rxd) begin
          st  <= S_START;
          cnt <= '0;
        end
        S_START: if (tick) begin
          if (cnt == MID) begin
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
            parb  <= 1'b0;
            st    <= rxd ? S_IDLE : S_DATA;
          end else cnt <= cnt + 1'b1;
        end
        S_DATA: if (tick) begin
          if (cnt == LAST) begin
            cnt        <= '0;
            shreg[idx] <= rxd;
            if (idx == last_idx) st <= (par_mode == PAR_NONE) ? S_STOP : S_PAR;
            else                 idx <= idx + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        S_PAR: if (tick) begin
          if (cnt == LAST) begin
            cnt  <= '0;
            parb <= rxd;
            st   <= S_STOP;
          end else cnt <= cnt + 1'b1;
        end
        S_STOP: if (tick) begin
          if (cnt == LAST) begin
            cnt         <= '0;
            done        <= 1'b1;
            result.data <= shreg;
            result.brk  <= is_brk;
            result.err  <= !is_brk && (!par_ok || !rxd);
            st          <= rxd ? S_IDLE : S_WAITHI;
          end else cnt <= cnt + 1'b1;
        end
        S_WAITHI: if (rxd) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/urx_hold.sv
module urx_hold
  import urx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  frame_t            fr,
  input  logic              rd,
  input  logic              clr_rx,
  input  logic              clr_err,
  input  logic              clr_brk,
  output logic [CHAR_W-1:0] char_q,
  output logic              full_q,
  output logic              err_q,
  output logic              ovr_q,
  output logic              brk_q
);
  logic load;
  logic room;

  assign load = accept && !fr.brk && !clr_rx;
  assign room = !full_q || rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      char_q <= '0;
      full_q <= 1'b0;
      err_q  <= 1'b0;
      ovr_q  <= 1'b0;
      brk_q  <= 1'b0;
    end else begin
      if (clr_rx) begin
        full_q <= 1'b0;
        char_q <= '0;
      end else if (load && room) begin
        full_q <= 1'b1;
        char_q <= fr.data;
      end else if (rd) begin
        full_q <= 1'b0;
      end

      if (clr_err)                   err_q <= 1'b0;
      else if (load && room && fr.err) err_q <= 1'b1;

      if (clr_err)            ovr_q <= 1'b0;
      else if (load && !room) ovr_q <= 1'b1;

      if (clr_brk)                brk_q <= 1'b0;
      else if (accept && fr.brk)  brk_q <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import urx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              rxd,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_wdata,
  input  logic              mode_wr,
  input  logic [3:0]        mode_wdata,
  input  logic              rd,
  output logic [CHAR_W-1:0] rx_char,
  output logic [7:0]        status
);
  logic       rxd_s;
  logic       rx_en;
  logic [1:0] len_code;
  par_e       par_mode;
  logic       clr_rx, clr_err, clr_brk;
  logic       done;
  frame_t     fr;
  logic       full_q, err_q, ovr_q, brk_q;

  urx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(rxd), .q(rxd_s)
  );

  urx_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .rx_en(rx_en), .len_code(len_code), .par_mode(par_mode),
    .clr_rx(clr_rx), .clr_err(clr_err), .clr_brk(clr_brk)
  );

  urx_deser #(.OSR(OSR)) u_deser (
    .clk(clk), .rst(rst), .run(rx_en && !clr_rx),
    .tick(tick16), .rxd(rxd_s),
    .len_code(len_code), .par_mode(par_mode),
    .done(done), .result(fr)
  );

  urx_hold u_hold (
    .clk(clk), .rst(rst),
    .accept(done && rx_en), .fr(fr), .rd(rd),
    .clr_rx(clr_rx), .clr_err(clr_err), .clr_brk(clr_brk),
    .char_q(rx_char), .full_q(full_q),
    .err_q(err_q), .ovr_q(ovr_q), .brk_q(brk_q)
  );

  always_comb begin
    status          = '0;
    status[ST_BRK]  = brk_q;
    status[ST_ERR]  = err_q;
    status[ST_OVR]  = ovr_q;
    status[ST_FULL] = full_q;
    status[ST_RDY]  = full_q;
  end
endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk (
  input logic       clk,
  input logic       rst,
  input logic       ctl_wr,
  input logic [7:0] ctl_wdata,
  input logic       rd,
  input logic       rx_en,
  input logic [7:0] rx_char,
  input logic [7:0] status
);
  // R6: full and ready report the same holding state
  p_full_ready_r6: assert property (@(posedge clk) disable iff (rst)
    status[1] == status[0]);

  // R8: receiver reset empties the holding register
  p_rx_reset_r8: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_wdata[7:4] == 4'd1) |=> (status[1:0] == 2'b00));

  // R7: error clear drops error and overrun
  p_err_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_wdata[7:4] == 4'd3) |=> (status[5:4] == 2'b00));

  // R7: break clear drops break
  p_brk_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_wdata[7:4] == 4'd4) |=> !status[6]);

  // R7: error bit is sticky until its command
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (status[5] && !(ctl_wr && ctl_wdata[7:4] == 4'd3)) |=> status[5]);

  // R9: a disabled receiver delivers nothing
  p_disabled_r9: assert property (@(posedge clk) disable iff (rst)
    (!rx_en && !status[0]) |=> !status[0]);

  // R5: an unread character is never overwritten
  p_hold_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (status[0] && !rd && !(ctl_wr && ctl_wdata[7:4] == 4'd1)) |=> $stable(rx_char));
endmodule

bind uart_rx_status uart_rx_status_chk u_chk (
  .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .rd(rd), .rx_en(rx_en), .rx_char(rx_char), .status(status)
);

// File: tb/uart_rx_status_tb.sv
`timescale 1ns/1ps
module uart_rx_status_tb;
  localparam int BIT = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic       mode_wr = 1'b0;
  logic [3:0] mode_wdata = '0;
  logic       rd_dir = 1'b0;
  logic       rd_mon = 1'b0;
  logic       rd;
  logic [7:0] rx_char;
  logic [7:0] status;

  logic       auto_rd = 1'b0;
  logic [7:0] exp_q[$];
  int n_chk = 0;
  int n_bad = 0;

  assign rd = rd_dir | rd_mon;

  always #2 clk = ~clk;

  uart_rx_status u_dut (
    .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .rd(rd), .rx_char(rx_char), .status(status)
  );

  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tc++;
      tick16 = (tc % 4 == 0);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ctl(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0; ctl_wdata = '0;
  endtask

  task automatic set_mode(input logic [1:0] len, input logic [1:0] par);
    @(negedge clk); mode_wr = 1'b1; mode_wdata = {len, par};
    @(negedge clk); mode_wr = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk); rd_dir = 1'b1;
    @(negedge clk); rd_dir = 1'b0;
  endtask

  task automatic line(input logic v);
    rxd = v;
    repeat (BIT) @(negedge clk);
  endtask

  // driver: serializes one frame; pushes the expected character when asked
  task automatic send(input logic [7:0] d, input int nb, input logic [1:0] pm,
                      input bit bad_par, input logic stop_v, input bit push);
    logic [7:0] m;
    logic p;
    m = d & 8'((1 << nb) - 1);
    if (push) exp_q.push_back(m);
    line(1'b0);
    for (int i = 0; i < nb; i++) line(m[i]);
    if (pm != 2'd0) begin
      case (pm)
        2'd1:    p = ~(^m);
        2'd2:    p = ^m;
        default: p = 1'b0;
      endcase
      line(p ^ bad_par);
    end
    line(stop_v);
    rxd = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  // monitor: compares delivered characters with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (auto_rd && status[0]) begin
        if (exp_q.size() == 0) chk("R6 unexpected char", rx_char, 32'hx);
        else chk("R1/R10 scoreboard", rx_char, exp_q.pop_front());
        rd_mon = 1'b1;
        @(negedge clk);
        rd_mon = 1'b0;
      end
    end
  end

  initial begin
    #600000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (10) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 status", status, 0);
    chk("R11 rx_char", rx_char, 0);

    // R9: disabled after reset
    send(8'h55, 8, 2'd0, 0, 1'b1, 0);
    chk("R9 disabled ignores line", status[0], 0);
    ctl(8'h01);

    auto_rd = 1'b1;
    send(8'hA5, 8, 2'd0, 0, 1'b1, 1);
    send(8'h3C, 8, 2'd0, 0, 1'b1, 1);
    send(8'h00, 8, 2'd0, 0, 1'b1, 1);
    send(8'hFF, 8, 2'd0, 0, 1'b1, 1);
    set_mode(2'd2, 2'd2);
    send(8'h5A, 7, 2'd2, 0, 1'b1, 1);
    send(8'hFF, 7, 2'd2, 0, 1'b1, 1);
    set_mode(2'd1, 2'd1);
    send(8'h2B, 6, 2'd1, 0, 1'b1, 1);
    send(8'h15, 6, 2'd1, 0, 1'b1, 1);
    set_mode(2'd0, 2'd3);
    send(8'h1F, 5, 2'd3, 0, 1'b1, 1);
    send(8'hEA, 5, 2'd3, 0, 1'b1, 1);
    set_mode(2'd3, 2'd1);
    send(8'hC3, 8, 2'd1, 0, 1'b1, 1);
    repeat (10) @(negedge clk);
    auto_rd = 1'b0;
    chk("R1 scoreboard drained", exp_q.size(), 0);
    chk("R2 good parity no error", status[5], 0);

    // R2: even parity mismatch
    set_mode(2'd3, 2'd2);
    send(8'h81, 8, 2'd2, 1, 1'b1, 0);
    chk("R2 parity error bit", status[5], 1);
    chk("R2 char delivered", status[0], 1);
    chk("R2 char value", rx_char, 8'h81);
    do_read();
    chk("R6 read clears ready", status[1:0], 0);
    ctl(8'h30);
    chk("R7 error cleared", status[5], 0);

    // R2: space parity with a one
    set_mode(2'd3, 2'd3);
    send(8'h42, 8, 2'd3, 1, 1'b1, 0);
    chk("R2 space parity error", status[5], 1);
    do_read();
    ctl(8'h30);

    // R3: framing error
    set_mode(2'd3, 2'd0);
    send(8'h12, 8, 2'd0, 0, 1'b0, 0);
    chk("R3 framing error bit", status[5], 1);
    chk("R3 not break", status[6], 0);
    chk("R3 char value", rx_char, 8'h12);
    do_read();
    ctl(8'h00);
    chk("R7 nop keeps error", status[5], 1);
    ctl(8'h30);
    chk("R7 error cleared after nop", status[5], 0);

    // R4: break
    send(8'h00, 8, 2'd0, 0, 1'b0, 0);
    chk("R4 break bit", status[6], 1);
    chk("R4 no error", status[5], 0);
    chk("R4 no char", status[0], 0);
    ctl(8'h30);
    chk("R7 error clear keeps break", status[6], 1);
    ctl(8'h40);
    chk("R7 break cleared", status[6], 0);
    send(8'h66, 8, 2'd0, 0, 1'b1, 0);
    chk("R4 rearmed char", rx_char, 8'h66);
    chk("R4 rearmed ready", status[0], 1);
    do_read();

    // R5: overrun
    send(8'h11, 8, 2'd0, 0, 1'b1, 0);
    send(8'h22, 8, 2'd0, 0, 1'b1, 0);
    chk("R5 overrun bit", status[4], 1);
    chk("R5 old char kept", rx_char, 8'h11);
    do_read();
    chk("R5 new char discarded", status[0], 0);
    ctl(8'h30);
    chk("R7 overrun cleared", status[4], 0);

    // R8: receiver reset keeps flags
    send(8'h44, 8, 2'd0, 0, 1'b0, 0);
    ctl(8'h10);
    chk("R8 holding emptied", status[1:0], 0);
    chk("R8 char zeroed", rx_char, 0);
    chk("R8 error kept", status[5], 1);
    ctl(8'h30);
    send(8'h77, 8, 2'd0, 0, 1'b1, 0);
    chk("R8 still enabled", rx_char, 8'h77);
    do_read();

    // R10: short glitch ignored
    rxd = 1'b0;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
    repeat (300) @(negedge clk);
    chk("R10 glitch ignored", status[0], 0);
    send(8'h5C, 8, 2'd0, 0, 1'b1, 0);
    chk("R10 after glitch", rx_char, 8'h5C);
    do_read();

    // R9: disable wins
    ctl(8'h03);
    send(8'h99, 8, 2'd0, 0, 1'b1, 0);
    chk("R9 disable wins", status[0], 0);
    ctl(8'h01);
    send(8'h9A, 8, 2'd0, 0, 1'b1, 0);
    chk("R9 re-enabled", rx_char, 8'h9A);
    chk("R11 unused status bits", {status[7], status[3:2]}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule